// File: doc/BRIEF.md
# Refresh Spacing Monitor

This block watches the decoded command stream sent to a DDR3 memory and polices how refreshes are spaced. A single counter tracks the clocks since the most recent refresh command. Each refresh clears it, and every other cycle adds one. The last refresh of the power-up sequence seeds the counter, so the counter runs even while the initialization flag is low.

Once initialization is done, the block raises a refresh request toward the controller a programmable margin before the refresh interval expires. It holds a busy flag from the first refresh of a burst until the post-refresh recovery window after the last refresh of that burst has passed. It also sets sticky error flags for four faults:
- an overdue refresh,
- an activate issued during the recovery window,
- a command other than NOOP or refresh while a multi-refresh burst is still incomplete,
- a mode-register set or calibration command after initialization.

The refresh interval is `TREFI_BASE` (1560 clocks) multiplied by `CLK_RATIO`. The recovery window is `TRFC` (64 clocks). The number of refreshes per burst is `BURST_LEN` (default 1).

Top module: `refresh_spacing_monitor`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `sinceRefresh` is 0, all four error flags are 0 and the refresh burst counts as complete.
- R2: `cmdIn` is decoded as 0 NOOP, 1 refresh, 2 activate, 3 read, 4 write, 5 precharge, 6 mode-register set, 7 calibration. The edge that samples a refresh sets `sinceRefresh` to 0. Every other edge adds one, saturating at 2^CNT_W-1. This also happens while `initDone` is low.
- R3: With `initDone` high, an activate sampled while `sinceRefresh` is below `TRFC` sets `errEarlyAct` at that edge. An activate sampled at exactly `TRFC` does not.
- R4: With `initDone` high, an edge at which `sinceRefresh` exceeds `TREFI_BASE*CLK_RATIO` sets `errOverdue`. A value equal to the interval does not.
- R5: A refresh that arrives while the previous burst is complete starts a new burst with count 1. Each further refresh adds one, and the burst is complete when the count reaches `BURST_LEN`. With `initDone` high and the burst incomplete, any sampled command other than NOOP or refresh sets `errBurstCmd`.
- R6: While `initDone` is low, no error flag is set and `refBusy` and `refreshDue` stay low. The burst is held complete, so the first refresh after initialization starts a new burst.
- R7: With `initDone` high, a mode-register set or calibration command sets `errIllegal`.
- R8: Every error flag, once set, stays set until reset.
- R9: `refreshDue` is high exactly when `initDone` is high and `sinceRefresh` is at least `TREFI_BASE*CLK_RATIO - DUE_MARGIN`. It falls in the cycle after a refresh is sampled.
- R10: `refBusy` is high exactly when `initDone` is high and either the burst is incomplete or `sinceRefresh` is below `TRFC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rstN | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | High once the power-up sequence has finished |
| cmdIn | input | 3 | Decoded command for this cycle (encoding in R2) |
| refreshDue | output | 1 | Request to the controller to issue a refresh soon |
| refBusy | output | 1 | Refresh burst or its recovery window in progress |
| sinceRefresh | output | CNT_W (12 by default) | Clocks since the last refresh |
| errOverdue | output | 1 | Sticky: refresh interval exceeded |
| errEarlyAct | output | 1 | Sticky: activate inside the recovery window |
| errBurstCmd | output | 1 | Sticky: illegal command inside an incomplete burst |
| errIllegal | output | 1 | Sticky: mode-register set or calibration after initialization |

## Verification
Every cycle, the assertions check these properties:
- the counter clears on refresh and steps otherwise,
- each error flag sets one edge after the condition that causes it,
- the flags are sticky,
- the request and busy outputs stay low before initialization.

Only the bench scenarios can show the exact boundaries: an activate at `TRFC-1` against `TRFC`, a count equal to the interval against one more, and the first cycle of the due margin. The bench scenarios also cover the counter's saturation, the way a second refresh completes a two-refresh burst, and the reseeding of the counter by the refresh issued during power-up.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [2:0] {
    CMD_NOOP      = 3'd0,
    CMD_REFRESH   = 3'd1,
    CMD_ACTIVATE  = 3'd2,
    CMD_READ      = 3'd3,
    CMD_WRITE     = 3'd4,
    CMD_PRECHARGE = 3'd5,
    CMD_MODESET   = 3'd6,
    CMD_ZQCAL     = 3'd7
  } cmd_e;

  // strobes from control to the interval counter
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
  } cnt_ctl_t;

  // comparator results from the interval counter
  typedef struct packed {
    logic overLimit;
    logic underRfc;
    logic inDueZone;
  } cnt_stat_t;

endpackage

// File: rtl/rsm_counter.sv
module rsm_counter
  import rsm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LIMIT  = 1560,
  parameter int RFC    = 64,
  parameter int DUE_AT = 1520
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ctl_t         ctl,
  output logic [CNT_W-1:0] count,
  output cnt_stat_t        stat
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)
      cntQ <= '0;
    else if (ctl.clearCnt)
      cntQ <= '0;
    else if (ctl.incCnt && (cntQ != MAX_CNT))
      cntQ <= cntQ + 1'b1;
  end

  assign count          = cntQ;
  assign stat.overLimit = (cntQ > CNT_W'(LIMIT));
  assign stat.underRfc  = (cntQ < CNT_W'(RFC));
  assign stat.inDueZone = (cntQ >= CNT_W'(DUE_AT));

  // R2: a refresh strobe clears the count on the following cycle
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearCnt |=> (cntQ == '0));

  // R2: a step strobe below saturation adds exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clearCnt && ctl.incCnt && (cntQ != MAX_CNT)) |=> (cntQ == $past(cntQ) + 1'b1));

  // R2: saturated count holds
  a_r2_sat: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clearCnt && (cntQ == MAX_CNT)) |=> (cntQ == MAX_CNT));

endmodule

// File: rtl/rsm_control.sv
module rsm_control
  import rsm_pkg::*;
#(
  parameter int BURST_LEN = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      initDone,
  input  cmd_e      cmd,
  input  cnt_stat_t stat,
  output cnt_ctl_t  ctl,
  output logic      refBusy,
  output logic      refreshDue,
  output logic      errOverdue,
  output logic      errEarlyAct,
  output logic      errBurstCmd,
  output logic      errIllegal
);

  localparam int BW = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN + 1);
  localparam logic [BW-1:0] FULL = BW'(BURST_LEN);

  logic [BW-1:0] burstCnt;
  logic          inBurst;
  logic          isRefresh;
  logic          burstLegal;
  logic          isSetup;

  assign isRefresh  = (cmd == CMD_REFRESH);
  assign burstLegal = (cmd == CMD_NOOP) || isRefresh;
  assign isSetup    = (cmd == CMD_MODESET) || (cmd == CMD_ZQCAL);
  assign inBurst    = (burstCnt < FULL);

  always_comb begin
    ctl.clearCnt = isRefresh;
    ctl.incCnt   = !isRefresh;
  end

  // burst position; held complete until initialization has finished
  always_ff @(posedge clk) begin
    if (!rstN || !initDone)
      burstCnt <= FULL;
    else if (isRefresh)
      burstCnt <= inBurst ? (burstCnt + 1'b1) : BW'(1);
  end

  // sticky fault flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errOverdue  <= 1'b0;
      errEarlyAct <= 1'b0;
      errBurstCmd <= 1'b0;
      errIllegal  <= 1'b0;
    end else if (initDone) begin
      if (stat.overLimit)                         errOverdue  <= 1'b1;
      if ((cmd == CMD_ACTIVATE) && stat.underRfc) errEarlyAct <= 1'b1;
      if (inBurst && !burstLegal)                 errBurstCmd <= 1'b1;
      if (isSetup)                                errIllegal  <= 1'b1;
    end
  end

  assign refBusy    = initDone && (inBurst || stat.underRfc);
  assign refreshDue = initDone && stat.inDueZone;

  // R3: early activate is flagged one edge later
  a_r3_early_act: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && (cmd == CMD_ACTIVATE) && stat.underRfc) |=> errEarlyAct);

  // R4: overdue interval is flagged one edge later
  a_r4_overdue: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && stat.overLimit) |=> errOverdue);

  // R5: non-NOOP, non-refresh command inside a burst is flagged
  a_r5_burst_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && inBurst && !burstLegal) |=> errBurstCmd);

  // R6: nothing requested or busy before initialization
  a_r6_pre_init: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (!refBusy && !refreshDue));

  // R7: setup commands after initialization are flagged
  a_r7_setup_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && isSetup) |=> errIllegal);

  // R8: flags never clear without reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errOverdue || errEarlyAct || errBurstCmd || errIllegal) |=>
      ((errOverdue  || !$past(errOverdue))  && (errEarlyAct || !$past(errEarlyAct)) &&
       (errBurstCmd || !$past(errBurstCmd)) && (errIllegal  || !$past(errIllegal))));

endmodule

// File: rtl/refresh_spacing_monitor.sv
module refresh_spacing_monitor
  import rsm_pkg::*;
#(
  parameter int CLK_RATIO  = 1,
  parameter int TREFI_BASE = 1560,
  parameter int TRFC       = 64,
  parameter int BURST_LEN  = 1,
  parameter int DUE_MARGIN = 40,
  localparam int TREFI     = TREFI_BASE * CLK_RATIO,
  localparam int CNT_W     = $clog2(TREFI + TRFC + 1) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initDone,
  input  logic [2:0]       cmdIn,
  output logic             refreshDue,
  output logic             refBusy,
  output logic [CNT_W-1:0] sinceRefresh,
  output logic             errOverdue,
  output logic             errEarlyAct,
  output logic             errBurstCmd,
  output logic             errIllegal
);

  localparam int DUE_AT = (TREFI > DUE_MARGIN) ? (TREFI - DUE_MARGIN) : 0;

  cnt_ctl_t  cntCtl;
  cnt_stat_t cntStat;
  cmd_e      cmd;

  assign cmd = cmd_e'(cmdIn);

  rsm_control #(
    .BURST_LEN(BURST_LEN)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .initDone   (initDone),
    .cmd        (cmd),
    .stat       (cntStat),
    .ctl        (cntCtl),
    .refBusy    (refBusy),
    .refreshDue (refreshDue),
    .errOverdue (errOverdue),
    .errEarlyAct(errEarlyAct),
    .errBurstCmd(errBurstCmd),
    .errIllegal (errIllegal)
  );

  rsm_counter #(
    .CNT_W (CNT_W),
    .LIMIT (TREFI),
    .RFC   (TRFC),
    .DUE_AT(DUE_AT)
  ) u_counter (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (cntCtl),
    .count(sinceRefresh),
    .stat (cntStat)
  );

endmodule

// File: tb/test_refresh_spacing_monitor.sv
`timescale 1ns/1ps
module test_refresh_spacing_monitor;
  import rsm_pkg::*;

  localparam int TREFI = 1560;
  localparam int TRFC  = 64;
  localparam int BL    = 2;
  localparam int MARG  = 40;
  localparam int DUEAT = TREFI - MARG;
  localparam int CW    = $clog2(TREFI + TRFC + 1) + 1;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initDone = 1'b0;
  logic [2:0]    cmdIn = 3'd0;
  logic          refreshDue, refBusy;
  logic [CW-1:0] sinceRefresh;
  logic          errOverdue, errEarlyAct, errBurstCmd, errIllegal;

  refresh_spacing_monitor #(
    .CLK_RATIO(1), .TREFI_BASE(TREFI), .TRFC(TRFC),
    .BURST_LEN(BL), .DUE_MARGIN(MARG)
  ) i_refresh_spacing_monitor (
    .clk(clk), .rstN(rstN), .initDone(initDone), .cmdIn(cmdIn),
    .refreshDue(refreshDue), .refBusy(refBusy), .sinceRefresh(sinceRefresh),
    .errOverdue(errOverdue), .errEarlyAct(errEarlyAct),
    .errBurstCmd(errBurstCmd), .errIllegal(errIllegal)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference model state
  int mCnt, mBurst;
  bit mOver, mAct, mBst, mIll, initV;

  function automatic bit expBusy();
    return initV && ((mBurst < BL) || (mCnt < TRFC));
  endfunction

  function automatic bit expDue();
    return initV && (mCnt >= DUEAT);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge(input cmd_e c);
    if (initV) begin
      if (mCnt > TREFI) mOver = 1'b1;
      if ((c == CMD_ACTIVATE) && (mCnt < TRFC)) mAct = 1'b1;
      if ((mBurst < BL) && !((c == CMD_NOOP) || (c == CMD_REFRESH))) mBst = 1'b1;
      if ((c == CMD_MODESET) || (c == CMD_ZQCAL)) mIll = 1'b1;
    end
    if (!initV) mBurst = BL;
    else if (c == CMD_REFRESH) mBurst = (mBurst >= BL) ? 1 : mBurst + 1;
    if (c == CMD_REFRESH) mCnt = 0;
    else if (mCnt < MAXC) mCnt = mCnt + 1;
  endtask

  task automatic compareAll();
    chk("R2 sinceRefresh", int'(sinceRefresh), mCnt);
    chk("R4 errOverdue", int'(errOverdue), int'(mOver));
    chk("R3 errEarlyAct", int'(errEarlyAct), int'(mAct));
    chk("R5 errBurstCmd", int'(errBurstCmd), int'(mBst));
    chk("R7 errIllegal", int'(errIllegal), int'(mIll));
    chk("R9 refreshDue", int'(refreshDue), int'(expDue()));
    chk("R10 refBusy", int'(refBusy), int'(expBusy()));
  endtask

  task automatic step(input cmd_e c);
    cmdIn = c;
    @(posedge clk);
    modelEdge(c);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; initDone = 1'b0; cmdIn = CMD_NOOP;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mBurst = BL; mOver = 0; mAct = 0; mBst = 0; mIll = 0; initV = 0;
    // R1: reset state
    chk("R1 sinceRefresh", int'(sinceRefresh), 0);
    chk("R1 flags", int'({errOverdue, errEarlyAct, errBurstCmd, errIllegal}), 0);
    chk("R1 refBusy", int'(refBusy), 0);
  endtask

  task automatic runInit();
    for (int i = 0; i < 5; i++) step(CMD_NOOP);
    step(CMD_MODESET);
    step(CMD_ZQCAL);
    step(CMD_PRECHARGE);
    step(CMD_REFRESH);      // seeds the counter
    for (int i = 0; i < 3; i++) step(CMD_NOOP);
    // R6: setup commands before init leave no flag
    chk("R6 errIllegal before init", int'(errIllegal), 0);
    chk("R6 refreshDue before init", int'(refreshDue), 0);
    initDone = 1'b1; initV = 1'b1;
    #0.1;
    chk("R10 busy inside seeded recovery window", int'(refBusy), 1);
  endtask

  task automatic waitCnt(input int target);
    while (mCnt < target) step(CMD_NOOP);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unused;
    unused = $urandom(32'h5eed_1234);

    // R3 boundary: activate at TRFC-1 is flagged, sticky afterwards (R8)
    doReset(); runInit();
    step(CMD_REFRESH); step(CMD_NOOP); step(CMD_REFRESH);
    waitCnt(TRFC - 1);
    step(CMD_ACTIVATE);
    chk("R3 act at TRFC-1 flagged", int'(errEarlyAct), 1);
    for (int i = 0; i < 5; i++) step(CMD_READ);
    chk("R8 errEarlyAct sticky", int'(errEarlyAct), 1);

    // R3 boundary: activate at exactly TRFC is fine
    doReset(); runInit();
    step(CMD_REFRESH); step(CMD_REFRESH);
    waitCnt(TRFC);
    chk("R10 busy drops at TRFC", int'(refBusy), 0);
    step(CMD_ACTIVATE);
    chk("R3 act at TRFC not flagged", int'(errEarlyAct), 0);

    // R4 / R9 boundaries and R2 saturation
    doReset(); runInit();
    step(CMD_REFRESH); step(CMD_REFRESH);
    waitCnt(DUEAT - 1);
    chk("R9 due low one before margin", int'(refreshDue), 0);
    step(CMD_NOOP);
    chk("R9 due high at margin", int'(refreshDue), 1);
    waitCnt(TREFI);
    step(CMD_NOOP);
    chk("R4 count equal to interval not flagged", int'(errOverdue), 0);
    step(CMD_NOOP);
    chk("R4 count above interval flagged", int'(errOverdue), 1);
    waitCnt(MAXC);
    step(CMD_NOOP);
    chk("R2 saturation holds", int'(sinceRefresh), MAXC);
    step(CMD_REFRESH);
    chk("R9 due falls after refresh", int'(refreshDue), 0);
    chk("R8 errOverdue sticky after refresh", int'(errOverdue), 1);

    // R5: illegal command mid-burst
    doReset(); runInit();
    waitCnt(TRFC + 2);
    step(CMD_REFRESH);
    chk("R10 busy during incomplete burst", int'(refBusy), 1);
    step(CMD_READ);
    chk("R5 read mid-burst flagged", int'(errBurstCmd), 1);

    // R5: complete burst then read is legal
    doReset(); runInit();
    step(CMD_REFRESH); step(CMD_NOOP); step(CMD_REFRESH);
    step(CMD_READ);
    chk("R5 read after full burst legal", int'(errBurstCmd), 0);
    step(CMD_REFRESH);   // new burst, count 1
    step(CMD_WRITE);
    chk("R5 new burst after complete one", int'(errBurstCmd), 1);

    // R7: mode set and calibration after init
    doReset(); runInit();
    step(CMD_MODESET);
    chk("R7 mode set after init", int'(errIllegal), 1);
    doReset(); runInit();
    step(CMD_ZQCAL);
    chk("R7 calibration after init", int'(errIllegal), 1);

    // random legal traffic with periodic refresh bursts
    doReset(); runInit();
    for (int n = 0; n < 8000; n++) begin
      if (mBurst < BL) begin
        step(($urandom_range(0, 2) == 0) ? CMD_REFRESH : CMD_NOOP);
      end else if (expDue() || ($urandom_range(0, 399) == 0)) begin
        step(CMD_REFRESH);
      end else begin
        cmd_e c;
        c = cmd_e'($urandom_range(0, 5));
        if (c == CMD_REFRESH) c = CMD_NOOP;
        if ((c == CMD_ACTIVATE) && (mCnt < TRFC)) c = CMD_NOOP;
        step(c);
      end
    end
    chk("R8 no flags after legal traffic",
        int'({errOverdue, errEarlyAct, errBurstCmd, errIllegal}), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule